// File: doc/BRIEF.md
# Power-of-Two Clock Divider Bank

This block holds a set of independent clock dividers behind one byte-wide register port. All of them run from a core clock `clk` that is twice the parent clock rate. A divider whose ratio is `r` toggles its output every `r` core cycles, so the output period is `2r` core cycles, which is `r` parent periods. Each divider has its own 256-byte register window. The window for divider `i` starts at `BASE_ADDR + 0x100*i`. It holds a 3-bit exponent-coded divide factor, an enable register and a read-only busy flag.

When the enable bit changes, a settling count starts. The count decrements once per pulse of the `ref_tick` strobe, and its length is `2 + 3*r`. The output changes state only when the count expires. A running output always starts from its low phase. A stopping output always finishes its current high phase, so no shortened high pulse appears in either direction.

To change rate, software disables the divider, writes the new factor and enables the divider again. A factor written while the divider is enabled is stored at once, but the running output keeps its old ratio until the next enable.

Top module: `clkdiv_bank`

## Requirements
- R1: After reset, every control, enable and status register reads 0, and every divider output is low.
- R2: A write of offset 0x43 stores `wdata[2:0]` as the factor. A read of that offset returns `{5'b0, factor}`. Read data is registered and appears one cycle after the address is presented.
- R3: Bit 7 of offset 0x46 is the enable bit. Bits [6:0] of that register are stored as written, and reads of 0x46 return all 8 bits.
- R4: Factor `f` in 1..7 gives ratio `r = 2^(f-1)`, and factor 0 gives `r = 1`. A running output is high for `r` core cycles and low for `r` core cycles.
- R5: A write that changes the enable bit makes bit 0 of offset 0x48 (busy) read 1 for exactly `2 + 3*r` pulses of `ref_tick`. Core cycles without `ref_tick` do not shorten the count. The running/stopped target changes only at the edge where the count expires.
- R6: After an enable settles, the output first rises `r` core cycles after the expiry edge. It always starts from its low phase.
- R7: After a disable settles, the output completes any high phase in progress and then stays low. Every high phase that begins after the disable write lasts a full `r` cycles.
- R8: A factor written while the divider is enabled reads back at once but does not change the running ratio. The disable settle still uses the old ratio. The new factor takes effect, and sets the settle length, at the next enable.
- R9: Writes outside the windows of dividers `0..N_DIV-1`, or to unused offsets, change nothing. Reads of such addresses return 0.
- R10: A write to 0x46 that leaves bit 7 unchanged starts no settle count and does not disturb the output.
- R11: Dividers are independent. Enabling one leaves the outputs of the others unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock, twice the parent clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle reference strobe that paces the settle count |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W | Byte address: window select in the high bits, offset in the low 8 bits |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data for the address of the previous cycle |
| div_clk_o | output | N_DIV | Divided clock outputs, one per divider |

## Verification
Each result has a fixed due cycle. Take a write sampled at edge E, with `ref_tick` held high. Busy is set after E and clears after edge E+L, where L = 2+3r. The status read lags by one register, so the bench counts exactly L ones on the status readback starting one cycle after E. The first output rise is due after edge E+L+r. After a disable, the output must be low from edge E+L+r onward. Samples are taken at falling edges, and each task counts cycles from the write edge, so every check lands on the cycle where the value is due. The phase measurements then count consecutive high and low samples, and each count must equal `r`.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  // Width of the exponent-coded divide factor
  localparam int FACT_W   = 3;
  // Largest exponent reachable by the factor (factor max minus one)
  localparam int EXP_MAX  = (1 << FACT_W) - 2;
  // Phase counter width: holds ratio-1 for the largest ratio
  localparam int PH_W     = EXP_MAX;
  // Ratio width: holds 2^EXP_MAX
  localparam int RATIO_W  = PH_W + 1;
  // Settle counter width: holds 2 + 3 * 2^EXP_MAX
  localparam int SETTLE_W = PH_W + 3;

  // Register offsets within a window
  localparam logic [7:0] OFF_CTRL = 8'h43;
  localparam logic [7:0] OFF_EN   = 8'h46;
  localparam logic [7:0] OFF_STAT = 8'h48;
  localparam int         EN_BIT   = 7;

  typedef logic [FACT_W-1:0]   factor_t;
  typedef logic [RATIO_W-1:0]  ratio_t;
  typedef logic [SETTLE_W-1:0] settle_t;

  function automatic ratio_t ratio_of(factor_t f);
    ratio_t r;
    if (f == '0) r = ratio_t'(1);
    else         r = ratio_t'(1) << (f - factor_t'(1));
    return r;
  endfunction

  function automatic settle_t settle_of(factor_t f);
    return settle_t'(2) + settle_t'(3) * settle_t'(ratio_of(f));
  endfunction

endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs
  import clkdiv_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic              wr,
  input  logic [7:0]        off,
  input  logic [DATA_W-1:0] wdata,
  input  logic              busy,
  output logic              en_o,
  output factor_t           act_factor_o,
  output logic              load_o,
  output settle_t           load_val_o,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int SPARE_W = DATA_W - 1;

  factor_t            factor_q;
  factor_t            act_q;
  logic               en_q;
  logic [SPARE_W-1:0] spare_q;

  logic wr_ctrl;
  logic wr_en;
  logic en_new;

  assign wr_ctrl = hit && wr && (off == OFF_CTRL);
  assign wr_en   = hit && wr && (off == OFF_EN);
  assign en_new  = wdata[EN_BIT];

  // A change of the enable bit starts a settle count
  assign load_o     = wr_en && (en_new != en_q);
  // Enabling settles on the factor being applied; disabling on the running one
  assign load_val_o = en_new ? settle_of(factor_q) : settle_of(act_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      factor_q <= '0;
      act_q    <= '0;
      en_q     <= 1'b0;
      spare_q  <= '0;
    end else begin
      if (wr_ctrl) factor_q <= wdata[FACT_W-1:0];
      if (wr_en) begin
        en_q    <= en_new;
        spare_q <= wdata[SPARE_W-1:0];
        // Pending factor becomes active only on an enable edge
        if (en_new && !en_q) act_q <= factor_q;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit) begin
      case (off)
        OFF_CTRL: rdata_o = DATA_W'(factor_q);
        OFF_EN:   rdata_o = {en_q, spare_q};
        OFF_STAT: rdata_o = DATA_W'(busy);
        default:  rdata_o = '0;
      endcase
    end
  end

  assign en_o         = en_q;
  assign act_factor_o = act_q;

endmodule

// File: rtl/clkdiv_settle.sv
module clkdiv_settle
  import clkdiv_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    ref_tick,
  input  logic    load,
  input  settle_t load_val,
  input  logic    en,
  output logic    busy_o,
  output logic    tgt_o
);

  settle_t cnt_q;
  logic    tgt_q;
  logic    expire;

  // Count reaches zero on this edge; a reload takes precedence
  assign expire = !load && ref_tick && (cnt_q == settle_t'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tgt_q <= 1'b0;
    end else begin
      if (load)                            cnt_q <= load_val;
      else if (ref_tick && cnt_q != '0)    cnt_q <= cnt_q - settle_t'(1);
      if (expire) tgt_q <= en;
    end
  end

  assign busy_o = (cnt_q != '0);
  assign tgt_o  = tgt_q;

endmodule

// File: rtl/clkdiv_gen.sv
module clkdiv_gen
  import clkdiv_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    run,
  input  factor_t factor,
  output logic    clk_o
);

  ratio_t ph_q;
  ratio_t half;
  logic   out_q;
  logic   active;

  assign half   = ratio_of(factor);
  // Keep counting while a high phase is still in progress after a stop
  assign active = run || out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= '0;
      out_q <= 1'b0;
    end else if (active) begin
      if (ph_q >= half - ratio_t'(1)) begin
        ph_q  <= '0;
        out_q <= ~out_q;
      end else begin
        ph_q  <= ph_q + ratio_t'(1);
      end
    end else begin
      ph_q  <= '0;
      out_q <= 1'b0;
    end
  end

  assign clk_o = out_q;

endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
  import clkdiv_pkg::*;
#(
  parameter int               N_DIV     = 2,
  parameter int               ADDR_W    = 16,
  parameter int               DATA_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [N_DIV-1:0]  div_clk_o
);

  localparam int              WIN_W    = ADDR_W - 8;
  localparam logic [WIN_W-1:0] BASE_WIN = BASE_ADDR[ADDR_W-1:8];

  logic [WIN_W-1:0]  win;
  logic [7:0]        off;
  logic [N_DIV-1:0]  hit_w;
  logic [N_DIV-1:0]  busy_w;
  logic [N_DIV-1:0]  tgt_w;
  logic [N_DIV-1:0]  en_w;
  logic [DATA_W-1:0] rd_win [N_DIV];
  logic [DATA_W-1:0] rd_next;

  assign win = reg_addr[ADDR_W-1:8];
  assign off = reg_addr[7:0];

  for (genvar i = 0; i < N_DIV; i++) begin : g_div
    localparam logic [WIN_W-1:0] MY_WIN = BASE_WIN + WIN_W'(i);

    factor_t act_f;
    logic    load;
    settle_t load_val;

    assign hit_w[i] = (win == MY_WIN);

    clkdiv_regs #(.DATA_W(DATA_W)) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .hit          (hit_w[i]),
      .wr           (reg_wr),
      .off          (off),
      .wdata        (reg_wdata),
      .busy         (busy_w[i]),
      .en_o         (en_w[i]),
      .act_factor_o (act_f),
      .load_o       (load),
      .load_val_o   (load_val),
      .rdata_o      (rd_win[i])
    );

    clkdiv_settle u_settle (
      .clk      (clk),
      .rst_n    (rst_n),
      .ref_tick (ref_tick),
      .load     (load),
      .load_val (load_val),
      .en       (en_w[i]),
      .busy_o   (busy_w[i]),
      .tgt_o    (tgt_w[i])
    );

    clkdiv_gen u_gen (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (tgt_w[i]),
      .factor (act_f),
      .clk_o  (div_clk_o[i])
    );
  end

  always_comb begin
    rd_next = '0;
    for (int k = 0; k < N_DIV; k++) begin
      if (hit_w[k]) rd_next = rd_win[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_rdata <= '0;
    else        reg_rdata <= rd_next;
  end

endmodule

// File: rtl/clkdiv_bank_chk.sv
module clkdiv_bank_chk #(
  parameter int N_DIV = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ref_tick,
  input logic [N_DIV-1:0] busy,
  input logic [N_DIV-1:0] tgt,
  input logic [N_DIV-1:0] en,
  input logic [N_DIV-1:0] dclk
);

  for (genvar g = 0; g < N_DIV; g++) begin : g_chk
    AST_RISE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dclk[g]) |-> $past(tgt[g])); // R6

    AST_TGT_AT_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(tgt[g]) |-> ($past(busy[g]) && !busy[g])); // R5

    AST_BUSY_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (busy[g] && !ref_tick) |=> busy[g]); // R5

    AST_SETTLE_FOLLOWS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy[g]) |-> (tgt[g] == en[g])); // R5

    AST_STOPPED_STAYS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (!tgt[g] && !dclk[g]) |=> !dclk[g]); // R7
  end

endmodule

bind clkdiv_bank clkdiv_bank_chk #(.N_DIV(N_DIV)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ref_tick (ref_tick),
  .busy     (busy_w),
  .tgt      (tgt_w),
  .en       (en_w),
  .dclk     (div_clk_o)
);

// File: tb/clkdiv_bank_tb.sv
`timescale 1ns/1ps
module clkdiv_bank_tb;

  localparam int          N_DIV  = 2;
  localparam int          ADDR_W = 16;
  localparam int          DATA_W = 8;
  localparam logic [15:0] BASE   = 16'h2000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ref_tick = 1'b1;
  logic              reg_wr = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic [N_DIV-1:0]  div_clk_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  clkdiv_bank #(.N_DIV(N_DIV), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_ADDR(BASE)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_tick  (ref_tick),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .div_clk_o (div_clk_o)
  );

  function automatic logic [15:0] a_of(int idx, logic [7:0] off);
    return BASE + 16'(idx * 256) + 16'(off);
  endfunction

  function automatic int ratio(int f);
    return (f == 0) ? 1 : (1 << (f - 1));
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [15:0] a, output int v);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    v = int'(reg_rdata);
  endtask

  // Find the next rising edge, then measure one high and one low phase
  task automatic check_period(int idx, int r, string req);
    int hi = 0, lo = 0, guard = 0;
    while (div_clk_o[idx] && guard < 300) begin @(negedge clk); guard++; end
    while (!div_clk_o[idx] && guard < 600) begin @(negedge clk); guard++; end
    while (div_clk_o[idx] && hi < 300) begin hi++; @(negedge clk); end
    while (!div_clk_o[idx] && lo < 300) begin lo++; @(negedge clk); end
    chk({req, " high phase"}, hi, r);
    chk({req, " low phase"}, lo, r);
  endtask

  // Enable, count busy readbacks and the first rise, then measure phases
  task automatic do_enable(int idx, int r);
    int L = 2 + 3 * r;
    int busy_n = 0, rise = -1;
    wr(a_of(idx, 8'h46), 8'h80);
    reg_addr = a_of(idx, 8'h48);
    for (int n = 1; n <= L + r + 4 && rise < 0; n++) begin
      @(negedge clk);
      if (reg_rdata[0]) busy_n++;
      if (div_clk_o[idx]) rise = n;
    end
    chk("R5 enable settle length", busy_n, L);
    chk("R6 first rise after settle", rise, L + r);
    check_period(idx, r, "R4");
  endtask

  // Disable, check settle length, full high phases and final low level
  task automatic do_disable(int idx, int r);
    int L = 2 + 3 * r;
    int busy_n = 0, last_hi = 0, run_start = -1, late_hi = 0;
    bit prev;
    wr(a_of(idx, 8'h46), 8'h00);
    reg_addr = a_of(idx, 8'h48);
    prev = div_clk_o[idx];
    for (int n = 1; n <= L + 5 * r + 4; n++) begin
      @(negedge clk);
      if (reg_rdata[0]) busy_n++;
      if (div_clk_o[idx]) last_hi = n;
      if (div_clk_o[idx] && n >= L + r) late_hi++;
      if (div_clk_o[idx] && !prev) run_start = n;
      if (!div_clk_o[idx] && prev && run_start > 0) begin
        chk("R7 no short high pulse", n - run_start, r);
        run_start = -1;
      end
      prev = div_clk_o[idx];
    end
    chk("R5 disable settle length", busy_n, L);
    chk("R7 output low after stop", late_hi, 0);
    chk("R7 last high within window", int'(last_hi < L + r), 1);
  endtask

  task automatic t_reset();
    int v;
    rd(a_of(0, 8'h43), v); chk("R1 ctrl reset", v, 0);
    rd(a_of(0, 8'h46), v); chk("R1 enable reset", v, 0);
    rd(a_of(1, 8'h48), v); chk("R1 status reset", v, 0);
    chk("R1 outputs low", int'(div_clk_o), 0);
  endtask

  task automatic t_all_factors();
    int v;
    for (int f = 0; f < 8; f++) begin
      wr(a_of(0, 8'h43), 8'(f) | 8'hF8);
      rd(a_of(0, 8'h43), v);
      chk("R2 factor readback", v, f);
      do_enable(0, ratio(f));
      chk("R11 other divider idle", int'(div_clk_o[1]), 0);
      do_disable(0, ratio(f));
    end
  endtask

  task automatic t_hold_factor();
    int v;
    wr(a_of(0, 8'h43), 8'd2);
    do_enable(0, 2);
    wr(a_of(0, 8'h43), 8'd5);
    rd(a_of(0, 8'h43), v);
    chk("R8 held factor reads back", v, 5);
    check_period(0, 2, "R8 old ratio kept");
    do_disable(0, 2);
    do_enable(0, 16);
    do_disable(0, 16);
  endtask

  task automatic t_same_enable();
    int v;
    wr(a_of(0, 8'h43), 8'd2);
    do_enable(0, 2);
    wr(a_of(0, 8'h46), 8'h95);
    rd(a_of(0, 8'h48), v);
    chk("R10 no settle on same enable", v, 0);
    rd(a_of(0, 8'h46), v);
    chk("R3 enable register readback", v, 8'h95);
    check_period(0, 2, "R10 output undisturbed");
    do_disable(0, 2);
    rd(a_of(0, 8'h46), v);
    chk("R3 enable cleared", v, 0);
  endtask

  task automatic t_decode();
    int v;
    wr(a_of(0, 8'h43), 8'd3);
    wr(a_of(1, 8'h43), 8'd6);
    wr(a_of(N_DIV, 8'h43), 8'd7);
    wr(a_of(0, 8'h44), 8'hFF);
    rd(a_of(0, 8'h43), v); chk("R9 window 0 unchanged", v, 3);
    rd(a_of(1, 8'h43), v); chk("R9 window 1 stride", v, 6);
    rd(a_of(N_DIV, 8'h43), v); chk("R9 unmapped window reads 0", v, 0);
    rd(a_of(0, 8'h44), v); chk("R9 unused offset reads 0", v, 0);
  endtask

  task automatic t_ref_pacing();
    int busy_n = 0;
    wr(a_of(1, 8'h43), 8'd1);
    wr(a_of(1, 8'h46), 8'h80);
    reg_addr = a_of(1, 8'h48);
    for (int n = 0; n < 40; n++) begin
      @(negedge clk);
      ref_tick = ~ref_tick;
      if (reg_rdata[0]) busy_n++;
    end
    ref_tick = 1'b1;
    chk("R5 settle paced by ref_tick", int'(busy_n >= 9 && busy_n <= 11), 1);
    chk("R11 divider 0 untouched", int'(div_clk_o[0]), 0);
    check_period(1, 1, "R4 divider 1");
    do_disable(1, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_all_factors();
    t_hold_factor();
    t_same_enable();
    t_decode();
    t_ref_pacing();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule